// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Variable Page Size

This block is a fully associative address translation buffer whose contents are loaded entirely by refill software. Each entry covers an aligned pair of virtual pages, an even one and an odd one, and holds a separate physical frame for each half. Each entry also has its own page-size mask, so one entry can cover a large region while its neighbour covers a pair of small pages. Each entry carries an address-space identifier and a global flag that makes the identifier irrelevant.

The core uses the lookup port on every memory access. The lookup is combinational and returns a hit, the frame and its attributes, or an invalid-entry indication that lets software tell a refill miss from a protection-style miss. The probe port searches the table and returns the index of the matching entry, which software needs before it rewrites an existing mapping. An indexed write port and an indexed read port give software full access to the table. Readback uses packed words. A rotating replacement pointer gives refill code a victim slot, and it can be bumped by the same read that selects it. A flush command empties the whole table in one cycle. Independently of the table, the lookup flags a fixed uncacheable address window.

Top module: `sw_tlb`

## Requirements
- R1: An entry matches a request when it is live (at least one of its two valid bits set) and the request page-pair number (virtual page number without its lowest bit) equals the stored pair number on every bit that is clear in that entry's mask. Mask bits are set contiguously from the least significant bit, and each set bit doubles the page size.
- R2: The address-space test passes when the entry's global flag is set or the request identifier equals the stored 8-bit identifier. The global flag written is the AND of bit 0 of the two low write words.
- R3: The half is chosen by the virtual-page-number bit just above the masked bits: bit 0 for a mask of zero, bit k for a mask with k bits set. A value of 0 selects the even half and 1 selects the odd half. A match on a half whose valid bit is clear gives lk_invalid=1 and lk_hit=0. A match on a valid half gives lk_hit=1 with that half's frame, 3-bit cache attribute and dirty bit. No match gives both flags low.
- R4: When several entries match, the lowest index supplies the lookup result and the probe index.
- R5: The probe returns the zero-extended index of the matching entry, or all ones on pb_index (31 by default) when no live entry matches. The probe does not look at the per-half valid bits beyond liveness.
- R6: A write whose index is N_ENT or above changes no entry, including the entry that its low index bits would select.
- R7: For readback, each half's low word is frame<<6 | cache<<3 | dirty<<2 | valid<<1 | global. The high word is pair_number<<11 | identifier, and the mask word is mask<<11. Writes use the same low-word layout and take the pair number, identifier and mask unshifted.
- R8: A flush clears every entry to zero and sets the replacement pointer to 0 at the next clock edge. Flush takes priority over a write or a pointer bump in the same cycle.
- R9: With rd_from_ptr set, the read port shows the entry at the replacement pointer instead of rd_index. With rd_bump also set, the pointer advances by one at the next edge and wraps from N_ENT-1 to 0.
- R10: lk_uncached is 1 exactly when every bit set in 0xA0000000 is also set in lk_va, whatever the table holds.
- R11: After reset, every entry reads as zero, the pointer is 0, no probe matches and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W (32) | Lookup virtual address |
| lk_asid | input | ASID_W (8) | Lookup address-space identifier |
| lk_hit | output | 1 | Valid translation found |
| lk_invalid | output | 1 | Matched entry, but the selected half is not valid |
| lk_pfn | output | PFN_W (20) | Physical frame of the selected half |
| lk_cache | output | 3 | Cache attribute of the selected half |
| lk_dirty | output | 1 | Dirty (writable) bit of the selected half |
| lk_uncached | output | 1 | Address lies in the uncacheable, strictly ordered window |
| pb_vpn | input | VPN_W (20) | Probe virtual page number |
| pb_asid | input | ASID_W (8) | Probe identifier |
| pb_index | output | IW+1 (5) | Matching index, or all ones |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | IW+1 (5) | Write index |
| wr_pn | input | PN_W (19) | Page-pair number to store |
| wr_mask | input | PN_W (19) | Page mask to store |
| wr_asid | input | ASID_W (8) | Identifier to store |
| wr_lo0 | input | LO_W (26) | Even-half packed word |
| wr_lo1 | input | LO_W (26) | Odd-half packed word |
| flush | input | 1 | Clear the whole table and the pointer |
| rd_index | input | IW (4) | Read index |
| rd_from_ptr | input | 1 | Read at the replacement pointer |
| rd_bump | input | 1 | Advance the pointer after this read |
| rd_hi | output | HI_W (30) | Packed pair number and identifier |
| rd_lo0 | output | LO_W (26) | Packed even half |
| rd_lo1 | output | LO_W (26) | Packed odd half |
| rd_mask | output | HI_W (30) | Shifted mask |
| repl_ptr | output | IW (4) | Replacement pointer |

## Verification
Lookup, probe and read results are combinational. They are due in the same cycle as their inputs, so the bench drives inputs on the falling edge and compares results two nanoseconds later, before the next rising edge. Writes, flushes and pointer bumps take effect on the next rising edge, so every check that depends on them is queued no earlier than the falling edge after that edge. The driver pushes each expected value into the scoreboard at the moment the stimulus becomes valid, and the monitor drains the queue at its fixed sampling point.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Bit offsets of the packed readback words.
  localparam int unsigned HI_SHIFT  = 11;
  localparam int unsigned LO_ATTR_W = 6;

  typedef enum logic [1:0] {
    LK_MISS    = 2'd0,
    LK_HIT     = 2'd1,
    LK_INVALID = 2'd2
  } lk_stat_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned PN_W  = VPN_W - 1
) (
  input  logic              live,
  input  logic [PN_W-1:0]   ent_pn,
  input  logic [PN_W-1:0]   ent_mask,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_g,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] req_asid,
  output logic              hit,
  output logic              odd
);
  logic [PN_W-1:0]  keep;
  logic [VPN_W-1:0] span;
  logic [VPN_W-1:0] sel_bit;
  logic             pn_eq;
  logic             as_ok;

  always_comb begin
    keep    = ~ent_mask;
    span    = {ent_mask, 1'b1};
    sel_bit = span & ~(span >> 1);   // highest bit of the contiguous span
    pn_eq   = (req_vpn[VPN_W-1:1] & keep) == (ent_pn & keep);
    as_ok   = ent_g || (req_asid == ent_asid);
    hit     = live && pn_eq && as_ok;
    odd     = |(req_vpn & sel_bit);
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          bump,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = flush | bump;
    ptr_d  = ptr_q;
    if (flush)                ptr_d = '0;
    else if (ptr_q == LAST)   ptr_d = '0;
    else                      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  p_flush_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ptr_q == '0);
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !flush && ptr_q == LAST) |=> ptr_q == '0);
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !flush && ptr_q != LAST) |=> ptr_q == IW'($past(ptr_q) + 1'b1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !flush) |=> $stable(ptr_q));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int unsigned N_ENT      = 16,
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ASID_W     = 8,
  parameter int unsigned PFN_W      = 20,
  parameter logic [VA_W-1:0] UNC_PAT = 32'hA000_0000,
  localparam int unsigned IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int unsigned VPN_W = VA_W - PAGE_SHIFT,
  localparam int unsigned PN_W  = VPN_W - 1,
  localparam int unsigned LO_W  = PFN_W + tlb_pkg::LO_ATTR_W,
  localparam int unsigned HI_W  = PN_W + tlb_pkg::HI_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_invalid,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_cache,
  output logic              lk_dirty,
  output logic              lk_uncached,
  input  logic [VPN_W-1:0]  pb_vpn,
  input  logic [ASID_W-1:0] pb_asid,
  output logic [IW:0]       pb_index,
  input  logic              wr_en,
  input  logic [IW:0]       wr_index,
  input  logic [PN_W-1:0]   wr_pn,
  input  logic [PN_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic              flush,
  input  logic [IW-1:0]     rd_index,
  input  logic              rd_from_ptr,
  input  logic              rd_bump,
  output logic [HI_W-1:0]   rd_hi,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  output logic [HI_W-1:0]   rd_mask,
  output logic [IW-1:0]     repl_ptr
);
  import tlb_pkg::*;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cache;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [PN_W-1:0]   pn;
    logic [PN_W-1:0]   mask;
    logic [ASID_W-1:0] asid;
    logic              g;
    half_t             h0;
    half_t             h1;
  } ent_t;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // Unpack the write words.
  ent_t wr_ent;
  always_comb begin
    wr_ent.pn   = wr_pn;
    wr_ent.mask = wr_mask;
    wr_ent.asid = wr_asid;
    wr_ent.g    = wr_lo0[0] & wr_lo1[0];
    wr_ent.h0   = half_t'(wr_lo0[LO_W-1:1]);
    wr_ent.h1   = half_t'(wr_lo1[LO_W-1:1]);
  end

  ent_t             ent_q [N_ENT];
  logic [N_ENT-1:0] wr_sel;
  logic [N_ENT-1:0] live;
  logic [N_ENT-1:0] lk_m, lk_odd, pb_m, pb_odd_unused;
  logic [VPN_W-1:0] lk_vpn;

  assign lk_vpn = lk_va[VA_W-1:PAGE_SHIFT];

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    ent_t q, d;
    logic en;

    always_comb begin
      wr_sel[gi] = wr_en && !flush && (wr_index == (IW+1)'(gi));
      en         = flush | wr_sel[gi];
      d          = flush ? ent_t'('0) : wr_ent;
    end

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i)  q <= '0;
      else if (en) q <= d;
    end

    assign ent_q[gi] = q;
    assign live[gi]  = q.h0.valid | q.h1.valid;

    tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) i_lk_match (
      .live(live[gi]), .ent_pn(q.pn), .ent_mask(q.mask), .ent_asid(q.asid),
      .ent_g(q.g), .req_vpn(lk_vpn), .req_asid(lk_asid),
      .hit(lk_m[gi]), .odd(lk_odd[gi]));

    tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) i_pb_match (
      .live(live[gi]), .ent_pn(q.pn), .ent_mask(q.mask), .ent_asid(q.asid),
      .ent_g(q.g), .req_vpn(pb_vpn), .req_asid(pb_asid),
      .hit(pb_m[gi]), .odd(pb_odd_unused[gi]));
  end

  // Lookup: lowest matching index, then choose the half.
  logic          lk_any;
  logic [IW-1:0] lk_idx;
  tlb_first_hit #(.N(N_ENT), .IW(IW)) i_lk_pick (
    .req(lk_m), .any(lk_any), .idx(lk_idx));

  half_t    lk_half;
  lk_stat_e lk_stat;
  always_comb begin
    lk_half = lk_odd[lk_idx] ? ent_q[lk_idx].h1 : ent_q[lk_idx].h0;
    if (!lk_any)            lk_stat = LK_MISS;
    else if (lk_half.valid) lk_stat = LK_HIT;
    else                    lk_stat = LK_INVALID;
    lk_hit      = (lk_stat == LK_HIT);
    lk_invalid  = (lk_stat == LK_INVALID);
    lk_pfn      = lk_hit ? lk_half.pfn   : '0;
    lk_cache    = lk_hit ? lk_half.cache : '0;
    lk_dirty    = lk_hit & lk_half.dirty;
    lk_uncached = (lk_va & UNC_PAT) == UNC_PAT;
  end

  // Probe.
  logic          pb_any;
  logic [IW-1:0] pb_idx;
  tlb_first_hit #(.N(N_ENT), .IW(IW)) i_pb_pick (
    .req(pb_m), .any(pb_any), .idx(pb_idx));

  assign pb_index = pb_any ? {1'b0, pb_idx} : '1;

  // Replacement pointer and read port.
  tlb_repl_ptr #(.N(N_ENT), .IW(IW)) i_ptr (
    .clk(clk), .rst_n(rst_i), .flush(flush),
    .bump(rd_from_ptr & rd_bump), .ptr(repl_ptr));

  ent_t rd_ent;
  always_comb begin
    rd_ent  = ent_q[rd_from_ptr ? repl_ptr : rd_index];
    rd_hi   = {rd_ent.pn, {HI_SHIFT{1'b0}}} | HI_W'(rd_ent.asid);
    rd_mask = {rd_ent.mask, {HI_SHIFT{1'b0}}};
    rd_lo0  = {rd_ent.h0, rd_ent.g};
    rd_lo1  = {rd_ent.h1, rd_ent.g};
  end

  // Checks on the table.
  p_oob_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && wr_index >= (IW+1)'(N_ENT)) |-> wr_sel == '0);
  p_pick_r4: assert property (@(posedge clk) disable iff (!rst_i)
    lk_any |-> (lk_m[lk_idx] && ((lk_m & ((N_ENT'(1) << lk_idx) - 1'b1)) == '0)));
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_i)
    !(lk_hit && lk_invalid));
  p_probe_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (pb_index != '1) |-> pb_m[pb_index[IW-1:0]]);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_i)
    flush |=> live == '0);
endmodule

// File: tb/test_sw_tlb.sv
`timescale 1ns/1ps
module test_sw_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_invalid, lk_dirty, lk_uncached;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_cache;
  logic [19:0] pb_vpn = '0;
  logic [7:0]  pb_asid = '0;
  logic [4:0]  pb_index;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_index = '0;
  logic [18:0] wr_pn = '0, wr_mask = '0;
  logic [7:0]  wr_asid = '0;
  logic [25:0] wr_lo0 = '0, wr_lo1 = '0;
  logic        flush = 1'b0;
  logic [3:0]  rd_index = '0;
  logic        rd_from_ptr = 1'b0, rd_bump = 1'b0;
  logic [29:0] rd_hi, rd_mask;
  logic [25:0] rd_lo0, rd_lo1;
  logic [3:0]  repl_ptr;

  always #4 clk = ~clk;

  sw_tlb i_sw_tlb (
    .clk, .rst_n, .lk_va, .lk_asid, .lk_hit, .lk_invalid, .lk_pfn, .lk_cache,
    .lk_dirty, .lk_uncached, .pb_vpn, .pb_asid, .pb_index, .wr_en, .wr_index,
    .wr_pn, .wr_mask, .wr_asid, .wr_lo0, .wr_lo1, .flush, .rd_index,
    .rd_from_ptr, .rd_bump, .rd_hi, .rd_lo0, .rd_lo1, .rd_mask, .repl_ptr);

  // Output selectors for scoreboard items.
  localparam int S_HIT = 0, S_INV = 1, S_PFN = 2, S_CACHE = 3, S_DIRTY = 4,
                 S_UNC = 5, S_PB = 6, S_HI = 7, S_LO0 = 8, S_LO1 = 9,
                 S_MASK = 10, S_PTR = 11;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t sb[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      S_HIT:   return 32'(lk_hit);
      S_INV:   return 32'(lk_invalid);
      S_PFN:   return 32'(lk_pfn);
      S_CACHE: return 32'(lk_cache);
      S_DIRTY: return 32'(lk_dirty);
      S_UNC:   return 32'(lk_uncached);
      S_PB:    return 32'(pb_index);
      S_HI:    return 32'(rd_hi);
      S_LO0:   return 32'(rd_lo0);
      S_LO1:   return 32'(rd_lo1);
      S_MASK:  return 32'(rd_mask);
      default: return 32'(repl_ptr);
    endcase
  endfunction

  // Monitor: combinational results settle after the falling-edge drive.
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = observe(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(string tag, int sel, logic [31:0] v);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = v;
    sb.push_back(it);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [25:0] lo_word(int pfn, int c, bit d, bit v, bit g);
    return 26'((pfn << 6) | (c << 3) | (int'(d) << 2) | (int'(v) << 1) | int'(g));
  endfunction

  task automatic put(int idx, int pn, int mask, int asid, bit g,
                     int pfn0, int c0, bit d0, bit v0,
                     int pfn1, int c1, bit d1, bit v1);
    cyc();
    wr_en    = 1'b1;
    wr_index = 5'(idx);
    wr_pn    = 19'(pn);
    wr_mask  = 19'(mask);
    wr_asid  = 8'(asid);
    wr_lo0   = lo_word(pfn0, c0, d0, v0, g);
    wr_lo1   = lo_word(pfn1, c1, d1, v1, g);
    cyc();
    wr_en    = 1'b0;
  endtask

  task automatic look(logic [31:0] va, int asid);
    lk_va = va; lk_asid = 8'(asid);
  endtask

  task automatic probe(int vpn, int asid);
    pb_vpn = 20'(vpn); pb_asid = 8'(asid);
  endtask

  task automatic bump_n(int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      rd_from_ptr = 1'b1;
      rd_bump     = 1'b1;
    end
    cyc();
    rd_bump = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R11: reset state
    rd_index = 4'd0; look(32'h0, 0); probe(0, 0);
    expect_val("R11 rd_hi", S_HI, 0);
    expect_val("R11 rd_lo0", S_LO0, 0);
    expect_val("R11 ptr", S_PTR, 0);
    expect_val("R11 probe", S_PB, 32'h1F);
    expect_val("R11 hit", S_HIT, 0);
    expect_val("R11 inval", S_INV, 0);

    put(3, 'h12, 0, 5, 0, 'h111, 3, 1, 1, 'h222, 2, 0, 1);
    put(5, 'h40, 3, 9, 1, 'h300, 0, 0, 1, 'h301, 0, 0, 0);
    put(7, 'h12, 0, 5, 0, 'h999, 1, 0, 1, 'h998, 1, 0, 1);

    // R1/R3: even half of entry 3
    look(32'h0002_4000, 5);
    expect_val("R1 hit even", S_HIT, 1);
    expect_val("R4 pfn lowest index", S_PFN, 'h111);
    expect_val("R3 cache even", S_CACHE, 3);
    expect_val("R3 dirty even", S_DIRTY, 1);
    cyc();
    look(32'h0002_5000, 5);
    expect_val("R3 pfn odd", S_PFN, 'h222);
    expect_val("R3 dirty odd", S_DIRTY, 0);
    cyc();
    look(32'h0002_4000, 6);
    expect_val("R2 asid mismatch", S_HIT, 0);
    expect_val("R2 asid mismatch inval", S_INV, 0);
    cyc();
    // Global entry with mask 3
    look(32'h0008_1000, 'h77);
    expect_val("R2 global hit", S_HIT, 1);
    expect_val("R1 masked pfn", S_PFN, 'h300);
    cyc();
    look(32'h0008_6000, 0);
    expect_val("R3 odd invalid hit", S_HIT, 0);
    expect_val("R3 odd invalid flag", S_INV, 1);
    cyc();
    look(32'h0008_8000, 0);
    expect_val("R1 outside mask", S_HIT, 0);
    expect_val("R1 outside mask inval", S_INV, 0);
    probe('h24, 5);
    expect_val("R4 probe lowest", S_PB, 3);
    cyc();
    probe('h86, 0);
    expect_val("R5 probe masked", S_PB, 5);
    cyc();
    probe('h100, 5);
    expect_val("R5 probe miss", S_PB, 32'h1F);

    // R10
    cyc(); look(32'hA000_1000, 0);
    expect_val("R10 window", S_UNC, 1);
    cyc(); look(32'hE000_0000, 0);
    expect_val("R10 superset", S_UNC, 1);
    cyc(); look(32'h8000_0000, 0);
    expect_val("R10 partial", S_UNC, 0);
    cyc(); look(32'h2000_0000, 0);
    expect_val("R10 partial2", S_UNC, 0);

    // R7 readback
    cyc(); rd_index = 4'd3;
    expect_val("R7 hi", S_HI, 'h9005);
    expect_val("R7 lo0", S_LO0, 'h445E);
    expect_val("R7 lo1", S_LO1, 'h8892);
    expect_val("R7 mask0", S_MASK, 0);
    cyc(); rd_index = 4'd5;
    expect_val("R7 hi global", S_HI, 'h20009);
    expect_val("R7 lo0 global", S_LO0, 'hC003);
    expect_val("R7 lo1 global", S_LO1, 'hC041);
    expect_val("R7 mask shifted", S_MASK, 'h1800);

    // R6 out-of-range writes
    put(16, 'h55, 0, 1, 0, 'h123, 0, 0, 1, 'h124, 0, 0, 1);
    put(19, 'h66, 0, 1, 0, 'h125, 0, 0, 1, 'h126, 0, 0, 1);
    rd_index = 4'd0; probe('hAA, 1);
    expect_val("R6 entry0 untouched", S_HI, 0);
    expect_val("R6 no probe match", S_PB, 32'h1F);
    cyc(); rd_index = 4'd3;
    expect_val("R6 entry3 untouched", S_HI, 'h9005);

    // R9 pointer reads
    cyc(); rd_from_ptr = 1'b1; rd_bump = 1'b1;
    expect_val("R9 read at ptr0", S_HI, 0);
    expect_val("R9 ptr before bump", S_PTR, 0);
    cyc(); rd_bump = 1'b0;
    expect_val("R9 ptr after bump", S_PTR, 1);
    bump_n(2);
    expect_val("R9 ptr 3", S_PTR, 3);
    expect_val("R9 read via ptr", S_HI, 'h9005);
    cyc();
    expect_val("R9 no bump holds", S_PTR, 3);
    bump_n(13);
    expect_val("R9 wrap", S_PTR, 0);
    bump_n(2);
    expect_val("R9 ptr 2", S_PTR, 2);

    // R8 flush with a simultaneous bump
    cyc(); flush = 1'b1; rd_bump = 1'b1;
    cyc(); flush = 1'b0; rd_bump = 1'b0; rd_from_ptr = 1'b0;
    rd_index = 4'd3; look(32'h0002_4000, 5); probe('h24, 5);
    expect_val("R8 ptr cleared", S_PTR, 0);
    expect_val("R8 entry cleared", S_HI, 0);
    expect_val("R8 lo cleared", S_LO0, 0);
    expect_val("R8 no hit", S_HIT, 0);
    expect_val("R8 no probe", S_PB, 32'h1F);

    cyc(); cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule